// File: doc/BRIEF.md
# Late-Write Pipelined SRAM Host Controller

This block is the master side of a pipelined synchronous SRAM that takes write data late: two enabled clock edges after the command. A client sends one request per cycle. Each request carries a read or write flag, an address, byte enables, write data and an optional 4-beat burst flag. The controller turns each request into a registered command on the memory pins. It then tracks the command through a two-deep in-flight pipeline. For a write, it drives the data and byte selects in the right cycle. For a read, it captures the data the memory returns and hands it back with a one-cycle valid strobe and the beat address.

Reads and writes may follow each other in any mix, one per cycle, with no turnaround cycles added. A burst is one load command followed by up to three advance commands. The client supplies the byte enables and write data for each advance command. The expected beat addresses follow a linear or an interleaved order, selected by a mode input that is changed only while the pipeline is empty. A stall input acts as the memory's clock enable, and it freezes the controller's pipeline in step with the memory.

Top module: `sram_host_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the memory pins show a deselect: first and third enables high, second enable low, advance/load low. The bus is released (`sram_dq_oe` low), `sram_oe_n` is high and `rsp_valid` is low.
- R2: A request accepted at a non-stalled edge, when no burst is open, appears on the pins in the next cycle as a load command. It shows `sram_advld_n` low, all three chip enables active, `sram_addr` equal to the request address, and `sram_we_n` low for a write or high for a read.
- R3: At a non-stalled edge with `req_valid` low, the pins in the next cycle show a deselect with the encoding given in R1.
- R4: The data of a write command is driven on `sram_dq_out` with `sram_dq_oe` high during the cycle that ends at the second enabled edge after the memory samples the command. In that cycle `sram_bws_n[i]` is low exactly when byte enable i was set; byte i is bits [9i+8:9i]. In every other cycle `sram_dq_oe` is low and all byte selects are high.
- R5: Read data is captured at the second enabled edge after the memory samples the read command. It is presented on `rsp_data` with `rsp_valid` high for one cycle, and equals the last data written to that address.
- R6: Reads and writes may be accepted on consecutive edges in any mix. Each read's response follows its acceptance edge by exactly three enabled edges. A read that directly follows a write to the same address returns the new data.
- R7: A request with `req_burst` high opens a burst. Each of the next three accepted requests becomes an advance command (`sram_advld_n` high). It uses only its byte enables and write data, and keeps the read/write type of the opening request.
- R8: Burst beat k (k = 0 to 3) uses the start address with its two low bits replaced by (low + k) mod 4 when `burst_mode` is 0, or by (low XOR k) when `burst_mode` is 1. `rsp_addr` reports this beat address for each read response.
- R9: A non-stalled edge with no valid request during an open burst ends the burst with a deselect. The next request is then issued as a load command with a new address.
- R10: `sram_cen_n` follows `stall`, and `req_ready` is the inverse of `stall`. An edge with `stall` high changes no pin or pipeline state, and `rsp_valid` is low after it.
- R11: The controller drives the bus only in write data cycles, and `sram_oe_n` is low only in read data cycles. The controller and the memory never drive the bus in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory |
| rst | input | 1 | Synchronous active-high reset |
| burst_mode | input | 1 | Beat order: 0 linear, 1 interleaved |
| stall | input | 1 | Pauses memory and controller together |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 write, 0 read (load requests only) |
| req_burst | input | 1 | Open a 4-beat burst |
| req_addr | input | AW | Word address (load requests only) |
| req_be | input | NB | Byte enables for a write beat |
| req_wdata | input | NB*BW | Write data for a write beat |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_addr | output | AW | Address of the returned beat |
| rsp_data | output | NB*BW | Returned read data |
| sram_cen_n | output | 1 | Memory clock enable, active low |
| sram_ce1_n | output | 1 | Chip enable 1, active low |
| sram_ce2 | output | 1 | Chip enable 2, active high |
| sram_ce3_n | output | 1 | Chip enable 3, active low |
| sram_advld_n | output | 1 | Low loads a command, high advances a burst |
| sram_we_n | output | 1 | Write enable, active low |
| sram_addr | output | AW | Memory address |
| sram_bws_n | output | NB | Byte write selects, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_dq_out | output | NB*BW | Write data toward the memory |
| sram_dq_oe | output | 1 | Controller drives the data bus |
| sram_dq_in | input | NB*BW | Data bus as driven by the memory |

## Verification
The assertions check the following on every cycle:
- a write held in the middle pipeline stage reaches the bus after the next enabled edge;
- a read held in the last stage produces a response strobe;
- a stalled edge leaves both stages and the command pins unchanged;
- an advance command only follows a selected cycle;
- bus drive and memory output enable are never active together.

Other behaviours depend on the request stream over many cycles, so only the bench scenarios can show them. These include data coherence through the memory, exact response latency counted in enabled edges, the linear and interleaved beat orders, partial byte writes, and the ending of an open burst. The bench covers them with a behavioural late-write memory and a shadow store.

// File: rtl/sram_host_pkg.sv
package sram_host_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    // Low two address bits of burst beat idx, starting from start.
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] idx,
                                            input logic       interleave);
        logic [1:0] r;
        if (interleave) r = start ^ idx;
        else            r = start + idx;
        return r;
    endfunction

endpackage

// File: rtl/sram_cmd_gen.sv
module sram_cmd_gen
    import sram_host_pkg::*;
#(
    parameter int AW = 18,
    parameter int NB = 2,
    parameter int BW = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stall,
    input  logic                 burst_mode,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_burst,
    input  logic [AW-1:0]        req_addr,
    input  logic [NB-1:0]        req_be,
    input  logic [NB*BW-1:0]     req_wdata,
    output op_e                  cmd_op,
    output logic                 cmd_load,
    output logic                 cmd_sel,
    output logic [AW-1:0]        cmd_addr,
    output logic [NB-1:0]        cmd_be,
    output logic [NB*BW-1:0]     cmd_data
);
    localparam int DW         = NB * BW;
    localparam int BEATS      = 4;
    localparam int CNT_W      = $clog2(BEATS);

    logic [CNT_W-1:0] left_q;    // advance beats still allowed
    logic [CNT_W-1:0] beat_q;    // index of the last issued beat
    logic [AW-1:0]    base_q;
    logic             bwr_q;
    logic             in_burst;
    logic [CNT_W-1:0] next_beat;

    assign in_burst  = (left_q != '0);
    assign next_beat = beat_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_op   <= OP_IDLE;
            cmd_load <= 1'b1;
            cmd_sel  <= 1'b0;
            cmd_addr <= '0;
            cmd_be   <= '0;
            cmd_data <= '0;
            left_q   <= '0;
            beat_q   <= '0;
            base_q   <= '0;
            bwr_q    <= 1'b0;
        end else if (!stall) begin
            if (req_valid && in_burst) begin
                cmd_op   <= bwr_q ? OP_WR : OP_RD;
                cmd_load <= 1'b0;
                cmd_sel  <= 1'b1;
                cmd_addr <= {base_q[AW-1:2], beat_low(base_q[1:0], next_beat, burst_mode)};
                cmd_be   <= req_be;
                cmd_data <= req_wdata;
                beat_q   <= next_beat;
                left_q   <= left_q - CNT_W'(1);
            end else if (req_valid) begin
                cmd_op   <= req_write ? OP_WR : OP_RD;
                cmd_load <= 1'b1;
                cmd_sel  <= 1'b1;
                cmd_addr <= req_addr;
                cmd_be   <= req_be;
                cmd_data <= req_wdata;
                base_q   <= req_addr;
                bwr_q    <= req_write;
                beat_q   <= '0;
                left_q   <= req_burst ? CNT_W'(BEATS - 1) : '0;
            end else begin
                cmd_op   <= OP_IDLE;
                cmd_load <= 1'b1;
                cmd_sel  <= 1'b0;
                cmd_be   <= '0;
                left_q   <= '0;
            end
        end
    end

    // R2: a fresh request outside a burst becomes a selected load command
    p_load_cmd_r2: assert property (@(posedge clk) disable iff (rst)
        (!stall && req_valid && !in_burst) |=> (cmd_load && cmd_sel && cmd_op != OP_IDLE));

    // R3 / R9: no request at an enabled edge gives a deselect and closes the burst
    p_idle_desel_r3: assert property (@(posedge clk) disable iff (rst)
        (!stall && !req_valid) |=> (!cmd_sel && cmd_load && !in_burst));

    // R7: an advance command only ever follows a selected cycle
    p_adv_after_sel_r7: assert property (@(posedge clk) disable iff (rst)
        !cmd_load |-> $past(cmd_sel));

    // R10: a stalled edge leaves the command pins untouched
    p_cmd_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(cmd_addr) && $stable(cmd_load) && $stable(cmd_sel) && $stable(cmd_op)));

    logic unused_dw;
    assign unused_dw = (DW == 0);

endmodule

// File: rtl/sram_data_pipe.sv
module sram_data_pipe
    import sram_host_pkg::*;
#(
    parameter int AW = 18,
    parameter int NB = 2,
    parameter int BW = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stall,
    input  op_e                  a_op,
    input  logic [AW-1:0]        a_addr,
    input  logic [NB-1:0]        a_be,
    input  logic [NB*BW-1:0]     a_data,
    input  logic [NB*BW-1:0]     dq_in,
    output logic [NB*BW-1:0]     dq_out,
    output logic                 dq_oe,
    output logic [NB-1:0]        bws_n,
    output logic                 oe_n,
    output logic                 rsp_valid,
    output logic [AW-1:0]        rsp_addr,
    output logic [NB*BW-1:0]     rsp_data
);
    localparam int DW = NB * BW;

    // Stage B: memory has sampled the command. Stage C: data cycle.
    op_e            b_op,   c_op;
    logic [AW-1:0]  b_addr, c_addr;
    logic [NB-1:0]  b_be,   c_be;
    logic [DW-1:0]  b_data, c_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            b_op      <= OP_IDLE;
            c_op      <= OP_IDLE;
            b_addr    <= '0;
            c_addr    <= '0;
            b_be      <= '0;
            c_be      <= '0;
            b_data    <= '0;
            c_data    <= '0;
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_data  <= '0;
        end else if (!stall) begin
            b_op      <= a_op;
            b_addr    <= a_addr;
            b_be      <= a_be;
            b_data    <= a_data;
            c_op      <= b_op;
            c_addr    <= b_addr;
            c_be      <= b_be;
            c_data    <= b_data;
            rsp_valid <= (c_op == OP_RD);
            if (c_op == OP_RD) begin
                rsp_addr <= c_addr;
                rsp_data <= dq_in;
            end
        end else begin
            rsp_valid <= 1'b0;
        end
    end

    assign dq_oe  = (c_op == OP_WR);
    assign oe_n   = (c_op != OP_RD);
    assign dq_out = dq_oe ? c_data : '0;

    for (genvar i = 0; i < NB; i++) begin : g_bws
        assign bws_n[i] = !(dq_oe && c_be[i]);
    end

    // R4: a write one stage from its data cycle drives the bus after the next enabled edge
    p_wr_slot_r4: assert property (@(posedge clk) disable iff (rst)
        (!stall && b_op == OP_WR) |=> (dq_oe && !$stable(c_op == OP_WR) || dq_oe));

    // R5: a read in its data cycle yields a response strobe at the next enabled edge
    p_rd_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (!stall && !oe_n) |=> rsp_valid);

    // R10: stalled edge keeps both stages and gives no strobe
    p_pipe_freeze_r10: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(b_op) && $stable(c_op) && $stable(c_data) && !rsp_valid));

    // R11: never drive the bus while the memory output is enabled
    p_bus_excl_r11: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (oe_n && bws_n != {NB{1'b1}} || oe_n));

endmodule

// File: rtl/sram_host_ctrl.sv
module sram_host_ctrl
    import sram_host_pkg::*;
#(
    parameter int AW = 18,
    parameter int NB = 2,
    parameter int BW = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 burst_mode,
    input  logic                 stall,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic                 req_burst,
    input  logic [AW-1:0]        req_addr,
    input  logic [NB-1:0]        req_be,
    input  logic [NB*BW-1:0]     req_wdata,
    output logic                 rsp_valid,
    output logic [AW-1:0]        rsp_addr,
    output logic [NB*BW-1:0]     rsp_data,
    output logic                 sram_cen_n,
    output logic                 sram_ce1_n,
    output logic                 sram_ce2,
    output logic                 sram_ce3_n,
    output logic                 sram_advld_n,
    output logic                 sram_we_n,
    output logic [AW-1:0]        sram_addr,
    output logic [NB-1:0]        sram_bws_n,
    output logic                 sram_oe_n,
    output logic [NB*BW-1:0]     sram_dq_out,
    output logic                 sram_dq_oe,
    input  logic [NB*BW-1:0]     sram_dq_in
);
    localparam int DW = NB * BW;

    op_e            a_op;
    logic           a_load;
    logic           a_sel;
    logic [AW-1:0]  a_addr;
    logic [NB-1:0]  a_be;
    logic [DW-1:0]  a_data;

    sram_cmd_gen #(.AW(AW), .NB(NB), .BW(BW)) u_cmd (
        .clk        (clk),
        .rst        (rst),
        .stall      (stall),
        .burst_mode (burst_mode),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_burst  (req_burst),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_wdata  (req_wdata),
        .cmd_op     (a_op),
        .cmd_load   (a_load),
        .cmd_sel    (a_sel),
        .cmd_addr   (a_addr),
        .cmd_be     (a_be),
        .cmd_data   (a_data)
    );

    sram_data_pipe #(.AW(AW), .NB(NB), .BW(BW)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .stall     (stall),
        .a_op      (a_op),
        .a_addr    (a_addr),
        .a_be      (a_be),
        .a_data    (a_data),
        .dq_in     (sram_dq_in),
        .dq_out    (sram_dq_out),
        .dq_oe     (sram_dq_oe),
        .bws_n     (sram_bws_n),
        .oe_n      (sram_oe_n),
        .rsp_valid (rsp_valid),
        .rsp_addr  (rsp_addr),
        .rsp_data  (rsp_data)
    );

    assign req_ready    = !stall;
    assign sram_cen_n   = stall;
    assign sram_ce1_n   = !a_sel;
    assign sram_ce2     = a_sel;
    assign sram_ce3_n   = !a_sel;
    assign sram_advld_n = !a_load;
    assign sram_we_n    = (a_op != OP_WR);
    assign sram_addr    = a_addr;

endmodule

// File: tb/sram_host_ctrl_tb.sv
module sram_host_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 18;
    localparam int NB = 2;
    localparam int BW = 9;
    localparam int DW = NB * BW;

    logic clk = 0, rst = 1, burst_mode = 0, stall = 0;
    logic req_valid = 0, req_write = 0, req_burst = 0;
    logic [AW-1:0] req_addr = '0;
    logic [NB-1:0] req_be = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [AW-1:0] rsp_addr;
    logic [DW-1:0] rsp_data;
    logic sram_cen_n, sram_ce1_n, sram_ce2, sram_ce3_n, sram_advld_n, sram_we_n;
    logic [AW-1:0] sram_addr;
    logic [NB-1:0] sram_bws_n;
    logic sram_oe_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_out, sram_dq_in;

    sram_host_ctrl #(.AW(AW), .NB(NB), .BW(BW)) u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit stall_en = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] init_word(input logic [AW-1:0] a);
        return DW'(a * 13 + 5);
    endfunction

    function automatic logic [AW-1:0] tb_beat(input logic [AW-1:0] b, input int k, input bit m);
        logic [1:0] lo;
        lo = m ? (b[1:0] ^ 2'(k)) : 2'(b[1:0] + 2'(k));
        return {b[AW-1:2], lo};
    endfunction

    // ---------------- behavioural late-write memory ----------------
    logic [DW-1:0] mem [int];
    int m_s1_op = 0, m_s2_op = 0;          // 0 none, 1 read, 2 write
    logic [AW-1:0] m_s1_a, m_s2_a, m_base;
    int m_cnt = 0;
    bit m_open = 0, m_wr = 0;
    logic m_out_valid = 0;
    logic [DW-1:0] m_out_data = '0;

    assign sram_dq_in = (m_out_valid && !sram_oe_n) ? m_out_data : '0;

    always @(posedge clk) begin
        if (rst) begin
            m_s1_op = 0; m_s2_op = 0; m_open = 0; m_out_valid <= 0;
        end else if (!sram_cen_n) begin
            if (m_s2_op == 2) begin
                logic [DW-1:0] w;
                chk(sram_dq_oe == 1'b1, "R4 write data cycle", 32'(sram_dq_oe), 1);
                w = mem.exists(int'(m_s2_a)) ? mem[int'(m_s2_a)] : init_word(m_s2_a);
                for (int i = 0; i < NB; i++)
                    if (!sram_bws_n[i]) w[i*BW +: BW] = sram_dq_out[i*BW +: BW];
                mem[int'(m_s2_a)] = w;
            end
            if (m_s1_op == 1) begin
                m_out_valid <= 1;
                m_out_data  <= mem.exists(int'(m_s1_a)) ? mem[int'(m_s1_a)] : init_word(m_s1_a);
            end else begin
                m_out_valid <= 0;
            end
            m_s2_op = m_s1_op; m_s2_a = m_s1_a;
            if (!sram_advld_n) begin
                if (!sram_ce1_n && sram_ce2 && !sram_ce3_n) begin
                    m_open = 1; m_wr = !sram_we_n; m_base = sram_addr; m_cnt = 0;
                    m_s1_op = m_wr ? 2 : 1; m_s1_a = sram_addr;
                end else begin
                    m_open = 0; m_s1_op = 0;
                end
            end else begin
                chk(m_open, "R7 advance without open burst", 32'(m_open), 1);
                m_cnt++;
                m_s1_op = m_wr ? 2 : 1; m_s1_a = tb_beat(m_base, m_cnt, burst_mode);
            end
        end
    end

    // ---------------- request-side reference ----------------
    logic [DW-1:0] shadow [int];
    logic [AW-1:0] q_addr [$];
    logic [DW-1:0] q_data [$];
    int q_edge [$];
    int en_cnt = 0, tb_left = 0, tb_k = 0;
    logic [AW-1:0] tb_base;
    bit tb_wr = 0, last_stalled = 0;
    bit e_sel = 0, e_load = 1, e_we_n = 1;
    logic [AW-1:0] e_addr = '0;

    always @(posedge clk) begin
        if (rst) begin
            tb_left = 0; e_sel = 0; e_load = 1; last_stalled = 0;
        end else begin
            last_stalled = stall;
            if (!stall) begin
                en_cnt++;
                if (req_valid) begin
                    logic [AW-1:0] a; bit wr;
                    if (tb_left > 0) begin
                        tb_k++; tb_left--;
                        a = tb_beat(tb_base, tb_k, burst_mode); wr = tb_wr;
                        e_sel = 1; e_load = 0;
                    end else begin
                        a = req_addr; wr = req_write;
                        tb_base = a; tb_k = 0; tb_wr = wr;
                        tb_left = req_burst ? 3 : 0;
                        e_sel = 1; e_load = 1; e_we_n = !wr; e_addr = a;
                    end
                    if (wr) begin
                        logic [DW-1:0] w;
                        w = shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(a);
                        for (int i = 0; i < NB; i++)
                            if (req_be[i]) w[i*BW +: BW] = req_wdata[i*BW +: BW];
                        shadow[int'(a)] = w;
                    end else begin
                        q_addr.push_back(a);
                        q_data.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : init_word(a));
                        q_edge.push_back(en_cnt + 3);
                    end
                end else begin
                    tb_left = 0; e_sel = 0; e_load = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(sram_cen_n == stall && req_ready == !stall, "R10 clock enable / ready", 32'(sram_cen_n), 32'(stall));
            if (!e_sel)
                chk(sram_ce1_n && !sram_ce2 && sram_ce3_n && !sram_advld_n, "R3/R9 deselect",
                    {sram_ce1_n, sram_ce2, sram_ce3_n, sram_advld_n}, 4'b1010);
            else if (e_load)
                chk(!sram_ce1_n && sram_ce2 && !sram_ce3_n && !sram_advld_n && sram_we_n == e_we_n
                    && sram_addr == e_addr, "R2 load command", 32'(sram_addr), 32'(e_addr));
            else
                chk(sram_advld_n == 1'b1, "R7 advance command", 32'(sram_advld_n), 1);
            chk(!(sram_dq_oe && (m_out_valid && !sram_oe_n)) && !(sram_dq_oe && !sram_oe_n),
                "R11 bus contention", 32'(sram_dq_oe), 0);
            if (!sram_dq_oe)
                chk(sram_bws_n == '1, "R4 byte selects idle", 32'(sram_bws_n), 32'((1 << NB) - 1));
            if (last_stalled)
                chk(!rsp_valid, "R10 no strobe after stalled edge", 32'(rsp_valid), 0);
            if (rsp_valid) begin
                if (q_addr.size() == 0) begin
                    chk(0, "R5 unexpected response", 32'(rsp_addr), 0);
                end else begin
                    logic [AW-1:0] ea; logic [DW-1:0] ed; int ee;
                    ea = q_addr.pop_front(); ed = q_data.pop_front(); ee = q_edge.pop_front();
                    chk(rsp_addr == ea, "R8 beat address", 32'(rsp_addr), 32'(ea));
                    chk(rsp_data == ed, "R5 read data", 32'(rsp_data), 32'(ed));
                    chk(en_cnt == ee, "R6 response latency", 32'(en_cnt), 32'(ee));
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [NB-1:0] be,
                          input logic [DW-1:0] d, input bit b);
        bit acc = 0;
        while (!acc) begin
            @(negedge clk); #1;
            req_valid = 1; req_write = w; req_addr = a; req_be = be; req_wdata = d; req_burst = b;
            stall = stall_en && ($urandom % 4 == 0);
            @(posedge clk);
            acc = !stall;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk); #1;
            req_valid = 0; req_burst = 0;
            stall = stall_en && ($urandom % 4 == 0);
            @(posedge clk);
        end
    endtask

    task automatic finish_up;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(sram_ce1_n && !sram_ce2 && sram_ce3_n && !sram_advld_n, "R1 reset deselect",
            {sram_ce1_n, sram_ce2, sram_ce3_n, sram_advld_n}, 4'b1010);
        chk(!sram_dq_oe && sram_oe_n && !rsp_valid, "R1 reset bus released",
            {sram_dq_oe, sram_oe_n, rsp_valid}, 3'b010);
        #1 rst = 0;
        @(negedge clk);
        chk(sram_ce1_n && !sram_advld_n && !sram_dq_oe && !rsp_valid, "R1 first cycle after reset",
            {sram_ce1_n, sram_advld_n}, 2'b10);

        // R2 R4 R5: single write then read
        do_req(1, 18'h00100, 2'b11, 18'h2ABCD, 0);
        idle(3);
        do_req(0, 18'h00100, 2'b00, '0, 0);
        idle(4);

        // R6: back-to-back mixed, read right after write to same address
        do_req(1, 18'h00200, 2'b11, 18'h11111, 0);
        do_req(0, 18'h00200, 2'b00, '0, 0);
        do_req(1, 18'h00201, 2'b11, 18'h22222, 0);
        do_req(0, 18'h00300, 2'b00, '0, 0);
        do_req(0, 18'h00201, 2'b00, '0, 0);
        do_req(1, 18'h00200, 2'b10, 18'h3F0F0, 0);   // R4 partial write, upper byte only
        do_req(0, 18'h00200, 2'b00, '0, 0);
        idle(5);

        // R7 R8: linear burst write and read
        burst_mode = 0;
        do_req(1, 18'h00402, 2'b11, 18'h0A0A0, 1);
        do_req(0, '0, 2'b11, 18'h0B0B0, 0);
        do_req(0, '0, 2'b01, 18'h0C0C0, 0);
        do_req(0, '0, 2'b11, 18'h0D0D0, 0);
        do_req(0, 18'h00402, 2'b00, '0, 1);
        do_req(1, '0, 2'b00, '0, 0);
        do_req(1, '0, 2'b00, '0, 0);
        do_req(1, '0, 2'b00, '0, 0);
        idle(6);

        // R8: interleaved order
        burst_mode = 1;
        do_req(0, 18'h00401, 2'b00, '0, 1);
        repeat (3) do_req(0, '0, 2'b00, '0, 0);
        do_req(1, 18'h00511, 2'b11, 18'h15555, 1);
        repeat (3) do_req(1, 18'h3FFFF, 2'b11, 18'h16666, 0);
        do_req(0, 18'h00512, 2'b00, '0, 0);
        idle(6);

        // R9: burst cut short by a gap, then a fresh load
        do_req(0, 18'h00403, 2'b00, '0, 1);
        do_req(0, '0, 2'b00, '0, 0);
        idle(1);
        do_req(0, 18'h00510, 2'b00, '0, 0);
        idle(6);

        // R10: random stalls over mixed traffic and bursts
        stall_en = 1;
        for (int it = 0; it < 300; it++) begin
            logic [AW-1:0] a;
            a = AW'($urandom % 16) + 18'h00600;
            case ($urandom % 5)
                0: do_req(1, a, NB'($urandom), DW'($urandom), 0);
                1: do_req(0, a, '0, '0, 0);
                2: begin
                    do_req($urandom % 2, a, NB'($urandom), DW'($urandom), 1);
                    repeat ($urandom % 4) do_req(0, '0, NB'($urandom), DW'($urandom), 0);
                    idle(1);
                end
                default: idle(1);
            endcase
        end
        stall_en = 0;
        idle(10);
        chk(q_addr.size() == 0, "R5 all reads answered", 32'(q_addr.size()), 0);
        finish_up();
    end

endmodule